// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Interface

This block controls a multi-channel successive-approximation converter from a simple 32-bit register bus. Software releases the block from its soft-reset state, powers it up, selects one analog input with a one-hot mask, programs the length of the sample phase and then sets the enable bit to request one software-triggered conversion. The block counts out the sample phase, sends a one-cycle start pulse with the one-hot channel select to the converter, waits for the converter's done strobe and stores the 12-bit result in the result register of that channel.

Completion sets a per-channel status bit. A start request whose channel mask is not one-hot does not convert; it sets an error status bit instead. Status bits are cleared by writing ones to them. An interrupt output reports enabled status events, either as a level that follows the enabled status bits or as a single-clock pulse per event. Clearing the enable bit stops the block. An abort during the sample phase takes effect at once. A conversion already handed to the converter drains: busy stays set until its done strobe returns, and the result is thrown away.

Register offsets: 0x00 mode/control, 0x04 trigger configuration, 0x08 channel mask, 0x0C timing, 0x20 interrupt control, 0x24 status, 0x28 clock divide, 0x30 + 4*n result of channel n.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the registers read: 0x00 = 0, 0x04 = 0, 0x08 = 0, 0x0C = 0x000E0578, 0x20 = 0, 0x24 = 0, 0x28 = 4, every result register = 0.
- R2: Register 0x00 holds the enable at bit 0, a read-only busy flag at bit 1, power-up at bit 2 (1 = powered) and the reset-release at bit 15; a write of 1 to bit 1 has no effect on the readback.
- R3: While the release bit (0x00 bit 15) or the power bit (0x00 bit 2) is 0, writes to every other register are ignored, the enable bit cannot be set and no start pulse is issued.
- R4: Writing 0 to the release bit returns every register, status and result to its reset value.
- R5: Setting enable while the channel mask (0x08, one bit per channel) has no bit or more than one bit set issues no start pulse, leaves busy at 0 and sets status bit 16.
- R6: With a one-hot mask, the start pulse is one clock wide, carries the mask on the channel-select output, and rises S+1 clocks after the clock edge that stores the enable, where S is timing bits 15:0 and S = 0 is treated as 1.
- R7: The converter's 12-bit result is stored in bits 11:0 of register 0x30 + 4*n for channel n, with bits 31:12 read as 0, and status bit n is set on the same clock edge.
- R8: Busy reads 1 from the enabling write until the result is stored and reads 0 one clock after the done strobe is sampled.
- R9: Clearing enable during the sample phase drops busy one clock after the clearing write, with no start pulse; clearing it after the start pulse keeps busy at 1 until done returns, and the result and status of that channel stay unchanged.
- R10: Writing to 0x24 clears exactly the status bits written as 1; bits written as 0 keep their value.
- R11: With interrupt control bit 31 = 1 (level), the interrupt output is 1 while any status bit n with enable bit n set, or status bit 16 with enable bit 16 set, is 1.
- R12: With interrupt control bit 31 = 0 (pulse), each enabled status event gives an interrupt output high for exactly one clock, in the same clock that the status bit is first seen set.
- R13: The clock divide field (0x28 bits 8:0) accepts only the value 4; writes of any other value leave it unchanged.
- R14: Timing bits 31:24 always read 0 and bits 23:16 hold the written value; register 0x04 keeps only bits 0, 2, 4, 12 and 13 of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read data is 0 when low |
| reg_addr | input | AW (8) | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| cnv_start | output | 1 | One-clock start pulse to the converter |
| cnv_sel | output | NCH (9) | One-hot channel select, valid while busy |
| cnv_result | input | RES_W (12) | Converter result, valid with cnv_done |
| cnv_done | input | 1 | Converter completion strobe |
| irq | output | 1 | Interrupt, level or single-pulse |

## Verification
The bench counts clocks from the enabling write to the start pulse for a long and a zero sample setting; an off-by-one counter or a missing zero clamp shifts the pulse by one clock or hangs the sample phase. It drives masks with no bit and with two bits, and a design that trusted the mask would pulse start with an illegal select instead of flagging an error. It clears enable both before and after the start pulse: a design that aborts a live conversion would drop busy early, and one that ignores the abort would store a result it should discard. It also writes to the block while it is still held in soft reset or powered down, and looks for registers that did not go back to their defaults after a release cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Register byte offsets; software depends on these positions.
    localparam logic [7:0] OFS_MODE0  = 8'h00;
    localparam logic [7:0] OFS_MODE1  = 8'h04;
    localparam logic [7:0] OFS_CHSEL  = 8'h08;
    localparam logic [7:0] OFS_TIMING = 8'h0C;
    localparam logic [7:0] OFS_IRQCTL = 8'h20;
    localparam logic [7:0] OFS_STAT   = 8'h24;
    localparam logic [7:0] OFS_CLKDIV = 8'h28;
    localparam logic [7:0] OFS_RES0   = 8'h30;

    // Bit positions inside the control and interrupt registers.
    localparam int B_EN   = 0;
    localparam int B_BUSY = 1;
    localparam int B_PWR  = 2;
    localparam int B_SREL = 15;
    localparam int B_ERR  = 16;
    localparam int B_LVL  = 31;

    // Trigger configuration keeps only the defined bits.
    localparam logic [31:0] MODE1_MASK = 32'h0000_3015;

    // Reset values of the timing and divider fields.
    localparam logic [7:0]  CMP_DEF = 8'h0E;
    localparam logic [15:0] SMP_DEF = 16'h0578;
    localparam logic [8:0]  DIV_LEGAL = 9'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_START,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic lvl;
        logic err_ie;
    } irq_mode_s;

    // Index of the set bit in a one-hot vector (lowest wins if several).
    function automatic logic [4:0] oh2idx(input logic [31:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int SMP_W = 16,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [31:0]      wdata,
    input  logic             busy,
    output logic             srel,
    output logic             pwr,
    output logic             en,
    output logic [31:0]      mode1,
    output logic [NCH-1:0]   chsel,
    output logic [7:0]       cmp,
    output logic [SMP_W-1:0] smp,
    output logic [NCH-1:0]   ch_ie,
    output irq_mode_s        imode,
    output logic [8:0]       div,
    output logic             start_req,
    output logic             sel_err
);

    logic wr0;
    logic cfg_open;
    logic en_try;

    assign wr0      = wr && (addr == AW'(OFS_MODE0));
    assign cfg_open = srel && pwr;
    // A 0->1 enable write from a released, powered, idle block.
    assign en_try   = wr0 && wdata[B_EN] && wdata[B_SREL] && wdata[B_PWR]
                      && cfg_open && !en && !busy;
    assign start_req = en_try && $onehot(chsel);
    assign sel_err   = en_try && !$onehot(chsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            srel <= 1'b0;
            pwr  <= 1'b0;
            en   <= 1'b0;
        end else if (wr0) begin
            srel <= wdata[B_SREL];
            pwr  <= wdata[B_PWR];
            en   <= wdata[B_EN] && wdata[B_SREL] && wdata[B_PWR] && cfg_open;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !srel) begin
            mode1 <= '0;
            chsel <= '0;
            cmp   <= CMP_DEF;
            smp   <= SMP_W'(SMP_DEF);
            ch_ie <= '0;
            imode <= '0;
            div   <= DIV_LEGAL;
        end else if (wr && pwr) begin
            case (addr)
                AW'(OFS_MODE1):  mode1 <= wdata & MODE1_MASK;
                AW'(OFS_CHSEL):  chsel <= wdata[NCH-1:0];
                AW'(OFS_TIMING): begin
                    cmp <= wdata[23:16];
                    smp <= wdata[SMP_W-1:0];
                end
                AW'(OFS_IRQCTL): begin
                    ch_ie        <= wdata[NCH-1:0];
                    imode.err_ie <= wdata[B_ERR];
                    imode.lvl    <= wdata[B_LVL];
                end
                AW'(OFS_CLKDIV): begin
                    if (wdata[8:0] == DIV_LEGAL) div <= wdata[8:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int SMP_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             en,
    input  logic             start_req,
    input  logic [NCH-1:0]   chsel,
    input  logic [SMP_W-1:0] smp,
    input  logic             cnv_done,
    output logic             busy,
    output logic             cnv_start,
    output logic [NCH-1:0]   cnv_sel,
    output logic             store,
    output logic [CH_W-1:0]  store_ch
);

    seq_state_e       state;
    logic [SMP_W-1:0] cnt;
    logic [SMP_W-1:0] smp_eff;
    logic [NCH-1:0]   sel_q;

    assign smp_eff = (smp == '0) ? SMP_W'(1) : smp;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sel_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state <= ST_SAMPLE;
                        cnt   <= SMP_W'(1);
                        sel_q <= chsel;
                    end
                end
                ST_SAMPLE: begin
                    if (!en)                 state <= ST_IDLE;
                    else if (cnt >= smp_eff) state <= ST_START;
                    else                     cnt   <= cnt + 1'b1;
                end
                ST_START: state <= ST_WAIT;
                ST_WAIT: begin
                    if (cnv_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign cnv_start = (state == ST_START);
    assign cnv_sel   = busy ? sel_q : '0;
    assign store     = (state == ST_WAIT) && cnv_done && en;
    assign store_ch  = CH_W'(oh2idx(32'(sel_q)));

endmodule

// File: rtl/adc_seq_stat.sv
module adc_seq_stat
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int RES_W = 12,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hold,
    input  logic                      w1c,
    input  logic [NCH-1:0]            w1c_ch,
    input  logic                      w1c_err,
    input  logic                      store,
    input  logic [CH_W-1:0]           store_ch,
    input  logic [RES_W-1:0]          cnv_result,
    input  logic                      sel_err,
    input  logic [NCH-1:0]            ch_ie,
    input  irq_mode_s                 imode,
    output logic [NCH-1:0]            sts_ch,
    output logic                      sts_err,
    output logic [NCH-1:0][RES_W-1:0] res,
    output logic                      irq
);

    logic [NCH-1:0] evt_ch;
    logic           pulse_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign evt_ch[g] = store && (store_ch == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst || hold)    res[g] <= '0;
            else if (evt_ch[g]) res[g] <= cnv_result;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            sts_ch  <= '0;
            sts_err <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            sts_ch  <= (sts_ch & ~(w1c ? w1c_ch : '0)) | evt_ch;
            sts_err <= (sts_err && !(w1c && w1c_err)) || sel_err;
            pulse_q <= (|(evt_ch & ch_ie)) || (sel_err && imode.err_ie);
        end
    end

    assign irq = imode.lvl ? ((|(sts_ch & ch_ie)) || (sts_err && imode.err_ie))
                           : pulse_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int RES_W = 12,
    parameter int SMP_W = 16,
    parameter int AW    = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             cnv_start,
    output logic [NCH-1:0]   cnv_sel,
    input  logic [RES_W-1:0] cnv_result,
    input  logic             cnv_done,
    output logic             irq
);

    logic             srel, pwr, en, busy;
    logic [31:0]      mode1;
    logic [NCH-1:0]   chsel, ch_ie, sts_ch;
    logic [7:0]       cmp;
    logic [SMP_W-1:0] smp;
    logic [8:0]       div;
    irq_mode_s        imode;
    logic             start_req, sel_err, store, sts_err, w1c;
    logic [CH_W-1:0]  store_ch;
    logic [NCH-1:0][RES_W-1:0] res;
    logic [31:0]      rmux;

    adc_seq_regs #(.NCH(NCH), .SMP_W(SMP_W), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .srel(srel), .pwr(pwr), .en(en), .mode1(mode1),
        .chsel(chsel), .cmp(cmp), .smp(smp), .ch_ie(ch_ie), .imode(imode),
        .div(div), .start_req(start_req), .sel_err(sel_err)
    );

    adc_seq_fsm #(.NCH(NCH), .SMP_W(SMP_W)) u_fsm (
        .clk(clk), .rst(rst), .hold(!srel), .en(en), .start_req(start_req),
        .chsel(chsel), .smp(smp), .cnv_done(cnv_done), .busy(busy),
        .cnv_start(cnv_start), .cnv_sel(cnv_sel), .store(store),
        .store_ch(store_ch)
    );

    assign w1c = reg_wr && (reg_addr == AW'(OFS_STAT)) && srel && pwr;

    adc_seq_stat #(.NCH(NCH), .RES_W(RES_W)) u_stat (
        .clk(clk), .rst(rst), .hold(!srel), .w1c(w1c),
        .w1c_ch(reg_wdata[NCH-1:0]), .w1c_err(reg_wdata[B_ERR]),
        .store(store), .store_ch(store_ch), .cnv_result(cnv_result),
        .sel_err(sel_err), .ch_ie(ch_ie), .imode(imode), .sts_ch(sts_ch),
        .sts_err(sts_err), .res(res), .irq(irq)
    );

    always_comb begin
        rmux = '0;
        case (reg_addr)
            AW'(OFS_MODE0): begin
                rmux[B_EN]   = en;
                rmux[B_BUSY] = busy;
                rmux[B_PWR]  = pwr;
                rmux[B_SREL] = srel;
            end
            AW'(OFS_MODE1):  rmux = mode1;
            AW'(OFS_CHSEL):  rmux = 32'(chsel);
            AW'(OFS_TIMING): rmux = {8'h00, cmp, 16'(smp)};
            AW'(OFS_IRQCTL): begin
                rmux        = 32'(ch_ie);
                rmux[B_ERR] = imode.err_ie;
                rmux[B_LVL] = imode.lvl;
            end
            AW'(OFS_STAT): begin
                rmux        = 32'(sts_ch);
                rmux[B_ERR] = sts_err;
            end
            AW'(OFS_CLKDIV): rmux = 32'(div);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (reg_addr == AW'(int'(OFS_RES0) + 4 * i)) rmux = 32'(res[i]);
                end
            end
        endcase
    end

    assign reg_rdata = reg_rd ? rmux : '0;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int NCH       = 9,
    parameter int DRAIN_MAX = 32,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            srel,
    input logic            en,
    input logic            busy,
    input logic            cnv_start,
    input logic [NCH-1:0]  cnv_sel,
    input logic            sel_err,
    input logic            store,
    input logic [CH_W-1:0] store_ch,
    input logic [NCH-1:0]  sts_ch,
    input logic            sts_err
);

    logic [7:0] drain_cnt;

    always_ff @(posedge clk) begin
        if (rst || !(busy && !en)) drain_cnt <= '0;
        else if (drain_cnt != 8'hFF) drain_cnt <= drain_cnt + 1'b1;
    end

    assert_start_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        cnv_start |-> ($onehot(cnv_sel) && busy));

    assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
        cnv_start |=> !cnv_start);

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!srel && $past(!srel)) |-> (!busy && !cnv_start));

    assert_selerr_nostart_R5: assert property (@(posedge clk) disable iff (rst)
        sel_err |=> (!busy && sts_err));

    assert_store_status_R7: assert property (@(posedge clk) disable iff (rst)
        (store && srel) |=> (sts_ch[$past(store_ch)] && !busy));

    assert_idle_nosel_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cnv_sel == '0));

    assert_drain_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !en) |-> (drain_cnt < 8'(DRAIN_MAX)));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .srel(srel), .en(en), .busy(busy),
    .cnv_start(cnv_start), .cnv_sel(cnv_sel), .sel_err(sel_err),
    .store(store), .store_ch(store_ch), .sts_ch(sts_ch), .sts_err(sts_err)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int CLK_P = 10;
    localparam int NCH   = 9;
    localparam int LAT   = 3;

    localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_CH = 8'h08,
                           A_TM = 8'h0C, A_IC = 8'h20, A_ST = 8'h24,
                           A_DV = 8'h28, A_R0 = 8'h30;

    logic           clk = 0;
    logic           rst = 1;
    logic           reg_wr = 0, reg_rd = 0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           cnv_start;
    logic [NCH-1:0] cnv_sel;
    logic [11:0]    cnv_result = '0;
    logic           cnv_done = 0;
    logic           irq;

    int n_chk = 0, n_err = 0, n_starts = 0;
    logic [11:0] model_val = 12'h700;
    bit finished = 0;

    adc_seq_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnv_start(cnv_start), .cnv_sel(cnv_sel), .cnv_result(cnv_result),
        .cnv_done(cnv_done), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural converter: result = model_val + channel index after LAT clocks.
    initial begin
        forever begin
            @(negedge clk);
            if (cnv_start) begin
                int idx;
                idx = 0;
                n_starts++;
                for (int i = 0; i < NCH; i++) if (cnv_sel[i]) idx = i;
                repeat (LAT) @(posedge clk);
                #1;
                cnv_done   = 1;
                cnv_result = model_val + 12'(idx);
                @(posedge clk);
                #1;
                cnv_done = 0;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_rd = 0; reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        reg_rd = 0;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd32(a, v);
        chk(tag, v, exp);
    endtask

    // Programs channel and sample length, enables, and times the conversion.
    task automatic run_conv(input int ch, input int smp,
                            output int t_start, output int t_idle,
                            output int irq_hi, output int pulses,
                            output logic [NCH-1:0] sel_seen, output bit busy_ok);
        int k;
        wr32(A_M0, 32'h8004);
        wr32(A_CH, 32'(1 << ch));
        wr32(A_TM, 32'h000E_0000 | 32'(smp));
        wr32(A_M0, 32'h8005);
        reg_addr = A_M0; reg_rd = 1;
        t_start = 0; t_idle = 0; irq_hi = 0; pulses = 0; sel_seen = '0; busy_ok = 1;
        for (k = 1; k < 5000; k++) begin
            #1;
            if (irq) irq_hi++;
            if (cnv_start) begin
                pulses++;
                if (t_start == 0) begin t_start = k; sel_seen = cnv_sel; end
            end
            if (!reg_rdata[1]) begin t_idle = k; break; end
            @(negedge clk);
        end
        if (t_idle == 1) busy_ok = 0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            #1;
            if (irq) irq_hi++;
        end
        reg_rd = 0;
    endtask

    task automatic t_reset();
        rdchk("R1 mode0", A_M0, 32'h0);
        rdchk("R1 mode1", A_M1, 32'h0);
        rdchk("R1 chsel", A_CH, 32'h0);
        rdchk("R1 timing", A_TM, 32'h000E_0578);
        rdchk("R1 irqctl", A_IC, 32'h0);
        rdchk("R1 status", A_ST, 32'h0);
        rdchk("R1 clkdiv", A_DV, 32'h4);
        rdchk("R1 result8", A_R0 + 8'd32, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_locked();
        int s0;
        s0 = n_starts;
        wr32(A_CH, 32'h1);
        rdchk("R3 chsel write while held", A_CH, 32'h0);
        wr32(A_M0, 32'h8000);
        wr32(A_CH, 32'h1);
        rdchk("R3 chsel write while powered down", A_CH, 32'h0);
        wr32(A_M0, 32'h8001);
        rdchk("R3 enable blocked while powered down", A_M0, 32'h8000);
        repeat (5) @(negedge clk);
        chk("R3 no start pulse", 32'(n_starts), 32'(s0));
    endtask

    task automatic t_mode0();
        wr32(A_M0, 32'h8004);
        rdchk("R2 release and power", A_M0, 32'h8004);
        wr32(A_M0, 32'h8006);
        rdchk("R2 busy read-only", A_M0, 32'h8004);
    endtask

    task automatic t_cfg();
        wr32(A_DV, 32'h8);
        rdchk("R13 illegal divide ignored", A_DV, 32'h4);
        wr32(A_DV, 32'h4);
        rdchk("R13 legal divide kept", A_DV, 32'h4);
        wr32(A_TM, 32'hFF12_0034);
        rdchk("R14 timing top byte reads zero", A_TM, 32'h0012_0034);
        wr32(A_M1, 32'hFFFF_FFFF);
        rdchk("R14 mode1 defined bits", A_M1, 32'h0000_3015);
    endtask

    task automatic t_convert();
        int ts, ti, ih, np;
        logic [NCH-1:0] sl;
        bit bo;
        wr32(A_ST, 32'h1_FFFF);
        run_conv(3, 5, ts, ti, ih, np, sl, bo);
        chk("R6 start delay smp=5", 32'(ts), 32'd6);
        chk("R6 single pulse", 32'(np), 32'd1);
        chk("R6 select one-hot", 32'(sl), 32'h8);
        chk("R8 busy fall after done", 32'(ti), 32'(6 + LAT + 1));
        chk("R8 busy set during conversion", 32'(bo), 32'h1);
        rdchk("R7 result ch3", A_R0 + 8'd12, 32'h0000_0703);
        rdchk("R7 status ch3", A_ST, 32'h8);
        model_val = 12'hFFE;
        run_conv(0, 0, ts, ti, ih, np, sl, bo);
        chk("R6 start delay smp=0", 32'(ts), 32'd2);
        rdchk("R7 result ch0 upper zero", A_R0, 32'h0000_0FFE);
        rdchk("R7 status ch0 and ch3", A_ST, 32'h9);
    endtask

    task automatic t_w1c();
        wr32(A_ST, 32'h8);
        rdchk("R10 clear ch3 only", A_ST, 32'h1);
        wr32(A_ST, 32'h0);
        rdchk("R10 zero write keeps", A_ST, 32'h1);
    endtask

    task automatic t_selerr();
        int s0;
        s0 = n_starts;
        wr32(A_M0, 32'h8004);
        wr32(A_CH, 32'h0);
        wr32(A_ST, 32'h1_FFFF);
        wr32(A_M0, 32'h8005);
        repeat (6) @(negedge clk);
        chk("R5 empty mask no start", 32'(n_starts), 32'(s0));
        rdchk("R5 empty mask not busy", A_M0, 32'h8005);
        rdchk("R5 empty mask error flag", A_ST, 32'h1_0000);
        wr32(A_M0, 32'h8004);
        wr32(A_CH, 32'h5);
        wr32(A_ST, 32'h1_0000);
        rdchk("R10 error flag cleared", A_ST, 32'h0);
        wr32(A_M0, 32'h8005);
        repeat (6) @(negedge clk);
        chk("R5 two-bit mask no start", 32'(n_starts), 32'(s0));
        rdchk("R5 two-bit mask error flag", A_ST, 32'h1_0000);
    endtask

    task automatic t_stop();
        int s0, k;
        logic [31:0] v;
        wr32(A_ST, 32'h1_FFFF);
        s0 = n_starts;
        wr32(A_M0, 32'h8004);
        wr32(A_CH, 32'h20);
        wr32(A_TM, 32'h000E_0014);
        wr32(A_M0, 32'h8005);
        wr32(A_M0, 32'h8004);
        @(negedge clk);
        reg_addr = A_M0; reg_rd = 1;
        #1 chk("R9 abort in sample drops busy", reg_rdata, 32'h8004);
        reg_rd = 0;
        repeat (30) @(negedge clk);
        chk("R9 abort in sample no start", 32'(n_starts), 32'(s0));
        // Drain case: abort after the start pulse.
        wr32(A_CH, 32'h40);
        wr32(A_TM, 32'h000E_0002);
        wr32(A_M0, 32'h8005);
        for (k = 0; k < 100; k++) begin
            if (cnv_start) break;
            @(negedge clk);
        end
        wr32(A_M0, 32'h8004);
        reg_addr = A_M0; reg_rd = 1;
        #1 chk("R9 busy held while draining", reg_rdata, 32'h8006);
        reg_rd = 0;
        for (k = 0; k < 50; k++) begin
            rd32(A_M0, v);
            if (!v[1]) break;
        end
        chk("R9 drain finishes", 32'(k < 50), 32'h1);
        rdchk("R9 drained result discarded", A_R0 + 8'd24, 32'h0);
        rdchk("R9 drained status untouched", A_ST, 32'h0);
    endtask

    task automatic t_irq_level();
        int ts, ti, ih, np;
        logic [NCH-1:0] sl;
        bit bo;
        wr32(A_ST, 32'h1_FFFF);
        wr32(A_IC, 32'h8000_0004);
        run_conv(1, 1, ts, ti, ih, np, sl, bo);
        chk("R11 disabled channel no irq", 32'(irq), 32'h0);
        run_conv(2, 1, ts, ti, ih, np, sl, bo);
        chk("R11 enabled channel level irq", 32'(irq), 32'h1);
        wr32(A_ST, 32'h4);
        #1 chk("R11 irq drops after clear", 32'(irq), 32'h0);
        wr32(A_IC, 32'h8001_0000);
        wr32(A_M0, 32'h8004);
        wr32(A_CH, 32'h0);
        wr32(A_M0, 32'h8005);
        @(negedge clk);
        #1 chk("R11 error level irq", 32'(irq), 32'h1);
        wr32(A_ST, 32'h1_FFFF);
        #1 chk("R11 error irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_irq_pulse();
        int ts, ti, ih, np;
        logic [NCH-1:0] sl;
        bit bo;
        wr32(A_IC, 32'h0000_0010);
        run_conv(4, 2, ts, ti, ih, np, sl, bo);
        chk("R12 single-clock pulse", 32'(ih), 32'd1);
        rdchk("R12 status remains set", A_ST, 32'h10);
        chk("R12 irq low afterwards", 32'(irq), 32'h0);
    endtask

    task automatic t_softreset();
        wr32(A_IC, 32'h8000_01FF);
        wr32(A_M1, 32'h0000_0004);
        wr32(A_M0, 32'h0004);
        wr32(A_M0, 32'h8004);
        rdchk("R4 timing default", A_TM, 32'h000E_0578);
        rdchk("R4 irqctl default", A_IC, 32'h0);
        rdchk("R4 status cleared", A_ST, 32'h0);
        rdchk("R4 chsel default", A_CH, 32'h0);
        rdchk("R4 mode1 default", A_M1, 32'h0);
        rdchk("R4 result ch3 cleared", A_R0 + 8'd12, 32'h0);
        chk("R4 irq low", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_locked();
        t_mode0();
        t_cfg();
        t_convert();
        t_w1c();
        t_selerr();
        t_stop();
        t_irq_level();
        t_irq_pulse();
        t_softreset();
        finish_run();
    end

endmodule